// File: doc/BRIEF.md
# Rectifier Body-Diode Conduction Timer

This block times how long the body diode of each synchronous-rectifier switch conducts after that switch is turned off. It serves several channels at once, two by default. Each channel has a gate command input and an active-low conduction flag. A falling edge on a channel's gate command arms a measurement. The block waits for a blanking interval and then opens a window of configured length. While the window is open, it counts the clock ticks on which the conduction flag is low.

When the window closes, the count is copied into that channel's result field and a one-cycle valid strobe is raised. A controller can then use each result to move the next cycle's turn-off edge. Conduction that falls outside the window is never counted, so ringing and reverse-current bursts do not disturb the result. The blanking and length settings are plain inputs that are shared by all channels.

Top module: `sr_cond_capture`

## Requirements
- R1: Let edge 0 be the rising clock edge on which a channel's gate command is first sampled low after having been sampled high. With blank setting B and effective length L, the conduction flag of that channel is sampled at edges B+1 through B+L.
- R2: A blank setting of 0 puts the first sample at edge 1, the clock edge right after the falling edge is seen.
- R3: Only flag-low samples inside the window add to the count. Low levels during blanking, after the close, or while no window is armed leave the result unchanged.
- R4: A length setting of 0 behaves exactly like a length of 1.
- R5: The count saturates at 127 (all ones in the 7-bit field) and never wraps. A window with 128 or more low samples reports 127.
- R6: The result field of channel c is result[c*7+6 : c*7]. It changes only at edge B+L, where it takes the new count, and result_vld[c] is high for exactly the one cycle that follows that edge. At all other times the field holds its last value.
- R7: Each window starts from a count of zero. A short measurement that follows a large one reports only its own samples.
- R8: A new falling edge that arrives while a window is in its blanking or open phase restarts timing from that new edge. The aborted window produces no strobe and its samples are dropped.
- R9: Channels are independent. Activity on one channel never strobes, nor alters the result of, another channel.
- R10: While reset is asserted and after its release, all result fields read 0 and no strobe is raised until a window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock; one tick is one count unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_cmd | input | NUM_CH | Gate command per channel; a falling edge arms a window |
| cond_n | input | NUM_CH | Conduction flag per channel, low while the body diode conducts |
| blank_cfg | input | BLANK_W | Blanking delay in ticks, shared by all channels |
| len_cfg | input | LEN_W | Window length in ticks, shared (0 acts as 1) |
| result | output | NUM_CH*CNT_W | Latched conduction counts, channel c in bits c*CNT_W upward |
| result_vld | output | NUM_CH | One-cycle strobe per channel at window close |

## Verification
Suppose a blank or length down-counter holds a wrong value. The strobe would then come one or more cycles away from edge B+L, or it would not come at all. The bench checks the strobe on every cycle of every window, so such a fault shows up on the very edge it goes wrong. A running count that was not cleared, that wrapped, or that took samples outside the window produces a result different from the overlap computed from the pulse and window bounds. That error is visible in the cycle right after the close. Leakage between channels is caught because the idle channel's strobe and result are watched for the whole of the active channel's measurement.

// File: rtl/sr_cap_pkg.sv
package sr_cap_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE  = 2'd0,
    WIN_BLANK = 2'd1,
    WIN_OPEN  = 2'd2
  } win_state_e;

endpackage

// File: rtl/sr_cap_window.sv
// Per-channel window sequencer: edge detect, blanking, open phase.
module sr_cap_window
  import sr_cap_pkg::*;
#(
  parameter int BLANK_W = 8,
  parameter int LEN_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_i,
  input  logic [BLANK_W-1:0] blank_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               open_o,
  output logic               clr_o,
  output logic               close_o
);

  win_state_e         st_q, st_d;
  logic               gate_q;
  logic [BLANK_W-1:0] bcnt_q, bcnt_d;
  logic [LEN_W-1:0]   lcnt_q, lcnt_d;
  logic [LEN_W-1:0]   len_eff;
  logic               fall;
  logic               bcnt_en, lcnt_en;

  always_comb begin
    fall    = gate_q & ~gate_i;
    len_eff = (len_i == '0) ? LEN_W'(1) : len_i;
    st_d    = st_q;
    bcnt_d  = bcnt_q;
    lcnt_d  = lcnt_q;
    clr_o   = 1'b0;
    close_o = 1'b0;
    if (fall) begin
      // a fresh edge always restarts timing
      if (blank_i == '0) begin
        st_d   = WIN_OPEN;
        lcnt_d = len_eff;
        clr_o  = 1'b1;
      end else begin
        st_d   = WIN_BLANK;
        bcnt_d = blank_i;
      end
    end else begin
      case (st_q)
        WIN_BLANK: begin
          if (bcnt_q == BLANK_W'(1)) begin
            st_d   = WIN_OPEN;
            lcnt_d = len_eff;
            clr_o  = 1'b1;
          end else begin
            bcnt_d = bcnt_q - BLANK_W'(1);
          end
        end
        WIN_OPEN: begin
          if (lcnt_q <= LEN_W'(1)) begin
            st_d    = WIN_IDLE;
            close_o = 1'b1;
          end else begin
            lcnt_d = lcnt_q - LEN_W'(1);
          end
        end
        default: ;
      endcase
    end
    bcnt_en = (bcnt_d != bcnt_q);
    lcnt_en = (lcnt_d != lcnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WIN_IDLE;
      gate_q <= 1'b0;
      bcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      gate_q <= gate_i;
      if (bcnt_en) bcnt_q <= bcnt_d;
      if (lcnt_en) lcnt_q <= lcnt_d;
    end
  end

  assign open_o = (st_q == WIN_OPEN);

endmodule

// File: rtl/sr_cap_counter.sv
// Saturating tick counter for one channel.
module sr_cap_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic             cond_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] upd_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  always_comb begin
    hit   = smp_i & ~cond_n_i;
    upd_o = (hit && (cnt_q != CNT_MAX)) ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (smp_i) begin
      cnt_q <= upd_o;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sr_cond_capture.sv
// Multi-channel windowed conduction-time capture.
module sr_cond_capture #(
  parameter int NUM_CH  = 2,
  parameter int CNT_W   = 7,
  parameter int BLANK_W = 8,
  parameter int LEN_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       gate_cmd,
  input  logic [NUM_CH-1:0]       cond_n,
  input  logic [BLANK_W-1:0]      blank_cfg,
  input  logic [LEN_W-1:0]        len_cfg,
  output logic [NUM_CH*CNT_W-1:0] result,
  output logic [NUM_CH-1:0]       result_vld
);

  logic [NUM_CH-1:0]            win_open;
  logic [NUM_CH-1:0]            win_clr;
  logic [NUM_CH-1:0]            win_close;
  logic [NUM_CH-1:0][CNT_W-1:0] run_cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_upd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] res_q;
    logic             vld_q;

    sr_cap_window #(
      .BLANK_W (BLANK_W),
      .LEN_W   (LEN_W)
    ) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .gate_i  (gate_cmd[c]),
      .blank_i (blank_cfg),
      .len_i   (len_cfg),
      .open_o  (win_open[c]),
      .clr_o   (win_clr[c]),
      .close_o (win_close[c])
    );

    sr_cap_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (win_clr[c]),
      .smp_i    (win_open[c]),
      .cond_n_i (cond_n[c]),
      .cnt_o    (run_cnt[c]),
      .upd_o    (cnt_upd[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= win_close[c];
        if (win_close[c]) res_q <= cnt_upd[c];
      end
    end

    assign result[c*CNT_W +: CNT_W] = res_q;
    assign result_vld[c]            = vld_q;
  end

endmodule

// File: rtl/sr_cond_capture_chk.sv
// Property checker, attached to the capture block by bind.
module sr_cond_capture_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 7
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            cond_n,
  input logic [NUM_CH*CNT_W-1:0]      result,
  input logic [NUM_CH-1:0]            result_vld,
  input logic [NUM_CH-1:0][CNT_W-1:0] run_cnt,
  input logic [NUM_CH-1:0]            win_open
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      result_vld[k] |=> !result_vld[k]);

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !result_vld[k] |-> result[k*CNT_W +: CNT_W] == $past(result[k*CNT_W +: CNT_W]));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (result_vld[k] && ($past(run_cnt[k]) == CNT_MAX)) |-> result[k*CNT_W +: CNT_W] == CNT_MAX);

    assert_clear_on_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open[k]) |-> run_cnt[k] == '0);

    assert_closed_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open[k] |=> (run_cnt[k] == $past(run_cnt[k])) || (run_cnt[k] == '0));

    assert_flag_high_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open[k] && cond_n[k]) |=> (run_cnt[k] == $past(run_cnt[k])) || (run_cnt[k] == '0));
  end

endmodule

bind sr_cond_capture sr_cond_capture_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cond_n     (cond_n),
  .result     (result),
  .result_vld (result_vld),
  .run_cnt    (run_cnt),
  .win_open   (win_open)
);

// File: tb/sr_cond_capture_bench.sv
module sr_cond_capture_bench;

  localparam int CLK_P = 10;
  localparam int CW    = 7;

  logic        clk;
  logic        rst_n;
  logic [1:0]  gate_cmd;
  logic [1:0]  cond_n;
  logic [7:0]  blank_cfg;
  logic [7:0]  len_cfg;
  logic [13:0] result;
  logic [1:0]  result_vld;

  int errors;
  int checks;
  int bvals [4] = '{0, 1, 2, 5};
  int lvals [4] = '{0, 1, 3, 7};
  int wvals [3] = '{1, 3, 6};

  sr_cond_capture u_sr_cond_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_cmd   (gate_cmd),
    .cond_n     (cond_n),
    .blank_cfg  (blank_cfg),
    .len_cfg    (len_cfg),
    .result     (result),
    .result_vld (result_vld)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int res_of(input int ch);
    return int'(result[ch*CW +: CW]);
  endfunction

  // One measurement on channel ch. Conduction is low at edges s..s+w-1
  // counted from the edge that sees the fall (edge 0).
  task automatic run_case(input int ch, input int b, input int l, input int s,
                          input int w, input string force_tag);
    int    le, close_e, lo, hi, exp, oth, oth_res;
    string tag;
    le      = (l == 0) ? 1 : l;
    close_e = b + le;
    lo      = (s > b + 1) ? s : b + 1;
    hi      = (s + w - 1 < close_e) ? s + w - 1 : close_e;
    exp     = (hi >= lo) ? hi - lo + 1 : 0;
    if (exp > 127) exp = 127;
    oth     = 1 - ch;
    oth_res = res_of(oth);
    if (force_tag != "")            tag = force_tag;
    else if (l == 0)                tag = "R4";
    else if (b == 0)                tag = "R2";
    else if (s <= b || s + w - 1 > close_e) tag = "R3";
    else                            tag = "R1";
    blank_cfg    = 8'(b);
    len_cfg      = 8'(l);
    gate_cmd[ch] = 1'b1;
    cond_n[ch]   = 1'b1;
    @(posedge clk); @(negedge clk);
    gate_cmd[ch] = 1'b0;
    cond_n[ch]   = (s <= 0 && 0 <= s + w - 1) ? 1'b0 : 1'b1;
    for (int j = 0; j <= close_e + 1; j++) begin
      @(posedge clk); @(negedge clk);
      // R6: strobe exactly one cycle after the closing edge
      check(result_vld[ch] == (j == close_e), "R6 strobe", int'(result_vld[ch]),
            (j == close_e) ? 1 : 0);
      if (j == close_e) check(res_of(ch) == exp, tag, res_of(ch), exp);
      if (j == close_e + 1) check(res_of(ch) == exp, "R6 hold", res_of(ch), exp);
      check(result_vld[oth] == 1'b0, "R9 strobe", int'(result_vld[oth]), 0);
      cond_n[ch] = (s <= j + 1 && j + 1 <= s + w - 1) ? 1'b0 : 1'b1;
    end
    check(res_of(oth) == oth_res, "R9 result", res_of(oth), oth_res);
  endtask

  // Arm a window and abort it after n edges with a new fall (R8).
  task automatic partial(input int ch, input int b, input int l, input int n);
    blank_cfg    = 8'(b);
    len_cfg      = 8'(l);
    gate_cmd[ch] = 1'b1;
    @(posedge clk); @(negedge clk);
    gate_cmd[ch] = 1'b0;
    cond_n[ch]   = 1'b0;
    for (int j = 0; j < n; j++) begin
      @(posedge clk); @(negedge clk);
      check(result_vld[ch] == 1'b0, "R8 no strobe", int'(result_vld[ch]), 0);
    end
  endtask

  initial begin
    errors    = 0;
    checks    = 0;
    rst_n     = 1'b0;
    gate_cmd  = 2'b11;
    cond_n    = 2'b11;
    blank_cfg = '0;
    len_cfg   = 8'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(result == '0, "R10 reset result", int'(result), 0);
    check(result_vld == '0, "R10 reset strobe", int'(result_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(result == '0, "R10 after release", int'(result), 0);
    check(result_vld == '0, "R10 strobe after release", int'(result_vld), 0);

    // sweep of blank, length, pulse start and width, alternating channels
    for (int bi = 0; bi < 4; bi++)
      for (int li = 0; li < 4; li++)
        for (int wi = 0; wi < 3; wi++) begin
          int le;
          le = (lvals[li] == 0) ? 1 : lvals[li];
          for (int s = 0; s <= bvals[bi] + le + 1; s++)
            run_case((s + wi) % 2, bvals[bi], lvals[li], s, wvals[wi], "");
        end

    // R5: saturation boundaries
    run_case(0, 0, 127, 0, 300, "R5 exact max");
    run_case(0, 2, 128, 0, 200, "R5 one over");
    run_case(1, 0, 150, 1, 149, "R5 long");
    // R7: fresh count right after a saturated window
    run_case(1, 0, 5, 0, 0, "R7 after saturate");
    run_case(1, 1, 4, 3, 1, "R7 small");

    // R8: restart during open phase and during blanking
    partial(0, 1, 20, 4);
    run_case(0, 1, 20, 0, 3, "R8 restart open");
    partial(1, 4, 2, 2);
    run_case(1, 4, 2, 5, 2, "R8 restart blank");
    partial(0, 0, 3, 2);
    run_case(0, 0, 3, 1, 3, "R8 restart zero blank");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog R1: got 0 expected 1 (run did not finish)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule